// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a single-data-rate synchronous DRAM from the memory side. On every rising clock edge it samples chip select, the three strobes, clock enable, bank address, the 12-bit address bus and the data-mask pins. It turns each sample into a decoded command and keeps open-row state for four banks. It holds the latest mode op-code and counts auto refreshes. It also follows entry into and exit from self refresh.

All outputs are registered. The decoded command, any error flag and the new bank, mode and refresh state appear after the clock edge that sampled the pins. A command flagged as a protocol error has no effect on any state. The data-mask pins drive two enables. The write enable applies to the data of the same cycle. The read enable lags by two clocks, which matches the output pipeline.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select high, the command is an inhibit. `cmd_o` reads 0 (NOP), and no bank, mode or refresh state changes.
- R2: With chip select low and clock enable high, `{ras_n,cas_n,we_n}` decode as follows. 111 gives 0 (NOP). 011 gives 1 (activate). 101 gives 2 (read). 100 gives 3 (write). 110 gives 4 (burst stop). 010 gives 5 (precharge one bank) when address bit 10 is low and 6 (precharge all) when it is high. 001 gives 7 (auto refresh). 000 gives 9 (load mode). The same 001 pattern with clock enable low gives 8 (self refresh entry).
- R3: An activate to an idle bank sets bit `ba` of `bank_open_o`. It stores the 12-bit address as that bank's row in `open_rows_o[ba*12 +: 12]`.
- R4: Precharge with address bit 10 low closes only bank `ba`. With bit 10 high it closes all four banks, and `ba` has no effect.
- R5: A read or write to an open bank with address bit 10 high closes that bank exactly BL cycles after the command edge. BL is 1<<mode[1:0] when mode bit 2 is 0, and 8 when mode bit 2 is 1. With bit 10 low the bank stays open.
- R6: An accepted auto refresh increments `refresh_row_o` by one.
- R7: Self refresh entry raises `self_ref_o`. While in self refresh every pin except clock enable is ignored and `cmd_o` is 0. The first sample with clock enable high clears `self_ref_o`. The command sampled on the following edge is also forced to NOP.
- R8: An accepted load mode stores the 12-bit address in `mode_o`.
- R9: `wr_mask_o` equals the data-mask value sampled at the latest edge. `rd_mask_o` equals the value sampled two edges before that.
- R10: `err_o` flags one error per command, and the flagged command changes no state. The bits are:
  - bit 0: a read or write to an idle bank.
  - bit 1: an activate to an open bank.
  - bit 2: an auto refresh, self refresh entry or load mode while any bank is open.
  - bit 3: clock enable low outside self refresh on anything other than self refresh entry.
- R11: After reset all banks are idle and `cmd_o`, `err_o`, `mode_o`, `refresh_row_o`, `self_ref_o` and both mask outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row, column or op-code field |
| dqm | input | 2 | Data-mask pins, one per byte lane |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 4 | Protocol error flags, one cycle per command |
| bank_open_o | output | 4 | One bit per bank, high while a row is open |
| open_rows_o | output | 48 | Open row of each bank, bank 0 in the low 12 bits |
| mode_o | output | 12 | Stored mode op-code |
| refresh_row_o | output | 12 | Auto refresh row counter |
| self_ref_o | output | 1 | High while in self refresh |
| wr_mask_o | output | 2 | Write data-mask enable, zero latency |
| rd_mask_o | output | 2 | Read data-mask enable, two-clock latency |

## Verification
Two events can fall on the same edge: the end of an auto-precharge countdown and a new command to the bank that is closing. The bench opens a bank with burst length two and reads it with auto precharge. On the edge where the countdown ends, it issues an activate to the same bank. That activate must be rejected with error bit 1 because the bank was still open before the edge, and the bank must read idle afterwards. A second activate one cycle later must be accepted. Every mode code on every bank, for both reads and writes, is swept by counting idle cycles until the bank closes.

// File: rtl/sdram_dec_pkg.sv
`timescale 1ns/1ps
// Shared command codes, power states and error bit positions for the
// SDRAM command tracker. Assumes a four-bit command report.
package sdram_dec_pkg;

    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_ACT    = 4'd1,
        CMD_RD     = 4'd2,
        CMD_WR     = 4'd3,
        CMD_BST    = 4'd4,
        CMD_PRE    = 4'd5,
        CMD_PREALL = 4'd6,
        CMD_AREF   = 4'd7,
        CMD_SREF   = 4'd8,
        CMD_LMR    = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_SELF = 2'd1,
        PS_EXIT = 2'd2
    } pwr_e;

    localparam int ERR_IDLE = 0;
    localparam int ERR_OPEN = 1;
    localparam int ERR_BUSY = 2;
    localparam int ERR_CKE  = 3;
    localparam int ERR_W    = 4;

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
// Combinational decode of the strobe pins into a command code.
// Assumes the caller samples the result on the clock edge; the
// auto-precharge bit only qualifies the precharge encoding here.
module sdram_cmd_decode
    import sdram_dec_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic ap_bit,
    output cmd_e cmd
);

    // Map chip select and the three strobes to one command.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = ap_bit ? CMD_PREALL : CMD_PRE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_slot.sv
`timescale 1ns/1ps
// State of one bank: open flag, open row and auto-precharge countdown.
// Assumes the caller raises act_i only for an idle bank and acc_i only
// for an open bank; requests are mutually exclusive per cycle.
module sdram_bank_slot #(
    parameter int ROW_W = 12,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             close_i,
    input  logic             acc_i,
    input  logic             acc_ap_i,
    input  logic [CNT_W-1:0] burst_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    logic [CNT_W-1:0] cnt_q;

    // Track open/close and count down a pending auto precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
            cnt_q  <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
            cnt_q  <= '0;
        end else if (close_i) begin
            open_o <= 1'b0;
            cnt_q  <= '0;
        end else if (acc_i) begin
            cnt_q  <= acc_ap_i ? burst_i : '0;
        end else if (cnt_q == CNT_W'(1)) begin
            open_o <= 1'b0;
            cnt_q  <= '0;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R5: a pending countdown only exists on an open bank.
    p_pending_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> open_o);

    // R5: the last count closes the bank unless a new access reloads it.
    p_count_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1) && !acc_i) |=> !open_o);

endmodule

// File: rtl/sdram_mask_pipe.sv
`timescale 1ns/1ps
// Data-mask enables: write path uses the mask of the current sample,
// read path delays it by RD_LAT further clocks. Assumes RD_LAT >= 1.
module sdram_mask_pipe #(
    parameter int W      = 2,
    parameter int RD_LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dqm,
    output logic [W-1:0] wr_mask_o,
    output logic [W-1:0] rd_mask_o
);

    logic [W-1:0] pipe_q [0:RD_LAT];
    logic [1:0]   age_q;

    // Shift the sampled mask down the read latency chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= RD_LAT; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= dqm;
            for (int i = 1; i <= RD_LAT; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    // Count clocks since reset so the latency check has history.
    always_ff @(posedge clk) begin
        if (!rst_n)               age_q <= '0;
        else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
    end

    assign wr_mask_o = pipe_q[0];
    assign rd_mask_o = pipe_q[RD_LAT];

    generate
        if (RD_LAT == 2) begin : g_lag_chk
            // R9: read enable repeats the write enable two clocks later.
            p_rd_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd3) |-> (rd_mask_o == $past(wr_mask_o, 2)));
        end
    endgenerate

endmodule

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
// Top of the SDRAM command decoder and bank tracker. Samples the pins
// each rising edge, validates the command against bank and power state,
// and updates banks, mode op-code, refresh counter and self refresh.
// Assumes BANKS is a power of two and AP_BIT < ROW_W.
module sdram_cmd_tracker
    import sdram_dec_pkg::*;
#(
    parameter int  ROW_W  = 12,
    parameter int  BANKS  = 4,
    parameter int  DQM_W  = 2,
    parameter int  AP_BIT = 10,
    parameter int  CNT_W  = 4,
    parameter int  RD_LAT = 2,
    localparam int BA_W   = $clog2(BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   cke,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       addr,
    input  logic [DQM_W-1:0]       dqm,
    output logic [3:0]             cmd_o,
    output logic [ERR_W-1:0]       err_o,
    output logic [BANKS-1:0]       bank_open_o,
    output logic [BANKS*ROW_W-1:0] open_rows_o,
    output logic [ROW_W-1:0]       mode_o,
    output logic [ROW_W-1:0]       refresh_row_o,
    output logic                   self_ref_o,
    output logic [DQM_W-1:0]       wr_mask_o,
    output logic [DQM_W-1:0]       rd_mask_o
);

    cmd_e             dec_cmd;
    cmd_e             eff_cmd;
    pwr_e             pstate_q;
    logic [ERR_W-1:0] err_n;
    logic             accept;
    logic             any_open;
    logic             sel_open;
    logic [CNT_W-1:0] burst_len;
    logic [ROW_W-1:0] row_q [BANKS];

    sdram_cmd_decode u_dec (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cke    (cke),
        .ap_bit (addr[AP_BIT]),
        .cmd    (dec_cmd)
    );

    assign any_open = |bank_open_o;
    assign sel_open = bank_open_o[ba];

    // Burst length from the stored mode op-code.
    always_comb begin
        if (mode_o[2]) burst_len = CNT_W'(8);
        else           burst_len = CNT_W'(1) << mode_o[1:0];
    end

    // Qualify the decoded command against power and bank state.
    always_comb begin
        eff_cmd = CMD_NOP;
        err_n   = '0;
        accept  = 1'b0;
        if (pstate_q == PS_RUN) begin
            eff_cmd = dec_cmd;
            if (!cke && dec_cmd != CMD_SREF) begin
                err_n[ERR_CKE] = 1'b1;
            end else begin
                case (dec_cmd)
                    CMD_ACT: begin
                        if (sel_open) err_n[ERR_OPEN] = 1'b1;
                        else          accept = 1'b1;
                    end
                    CMD_RD, CMD_WR: begin
                        if (!sel_open) err_n[ERR_IDLE] = 1'b1;
                        else           accept = 1'b1;
                    end
                    CMD_AREF, CMD_SREF, CMD_LMR: begin
                        if (any_open) err_n[ERR_BUSY] = 1'b1;
                        else          accept = 1'b1;
                    end
                    default: accept = 1'b1;
                endcase
            end
        end
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic hit;
            assign hit = (ba == BA_W'(b));

            sdram_bank_slot #(
                .ROW_W (ROW_W),
                .CNT_W (CNT_W)
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_i    (accept && eff_cmd == CMD_ACT && hit),
                .row_i    (addr),
                .close_i  (accept && (eff_cmd == CMD_PREALL ||
                                      (eff_cmd == CMD_PRE && hit))),
                .acc_i    (accept && (eff_cmd == CMD_RD || eff_cmd == CMD_WR) && hit),
                .acc_ap_i (addr[AP_BIT]),
                .burst_i  (burst_len),
                .open_o   (bank_open_o[b]),
                .row_o    (row_q[b])
            );

            assign open_rows_o[b*ROW_W +: ROW_W] = row_q[b];
        end
    endgenerate

    // Register the reported command and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o <= CMD_NOP;
            err_o <= '0;
        end else begin
            cmd_o <= eff_cmd;
            err_o <= err_n;
        end
    end

    // Store the mode op-code and advance the refresh row counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o        <= '0;
            refresh_row_o <= '0;
        end else if (accept) begin
            if (eff_cmd == CMD_LMR)  mode_o        <= addr;
            if (eff_cmd == CMD_AREF) refresh_row_o <= refresh_row_o + 1'b1;
        end
    end

    // Power state: run, self refresh, and one forced-NOP exit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pstate_q <= PS_RUN;
        end else begin
            case (pstate_q)
                PS_RUN:  if (accept && eff_cmd == CMD_SREF) pstate_q <= PS_SELF;
                PS_SELF: if (cke) pstate_q <= PS_EXIT;
                default: pstate_q <= PS_RUN;
            endcase
        end
    end

    assign self_ref_o = (pstate_q == PS_SELF);

    sdram_mask_pipe #(
        .W      (DQM_W),
        .RD_LAT (RD_LAT)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .dqm       (dqm),
        .wr_mask_o (wr_mask_o),
        .rd_mask_o (rd_mask_o)
    );

    // R1: an inhibit always reports NOP.
    p_inhibit_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_o == CMD_NOP));

    // R6: the refresh row only ever moves by one.
    p_refresh_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_row_o != $past(refresh_row_o)) |->
        (refresh_row_o == ROW_W'($past(refresh_row_o) + 1'b1)));

    // R7: with clock enable low, self refresh holds and refresh is frozen.
    p_self_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (self_ref_o && !cke) |=> (self_ref_o && $stable(refresh_row_o)));

    // R7: the cycle after leaving self refresh reports NOP too.
    p_exit_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(self_ref_o) |-> (cmd_o == CMD_NOP));

    // R8: the mode op-code only changes with a load mode report.
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_LMR) |-> $stable(mode_o));

    // R10: at most one error reason per command.
    p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_o));

endmodule

// File: tb/sdram_cmd_tracker_test.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n, cke;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [1:0]  dqm;
    logic [3:0]  cmd_o;
    logic [3:0]  err_o;
    logic [3:0]  bank_open_o;
    logic [47:0] open_rows_o;
    logic [11:0] mode_o;
    logic [11:0] refresh_row_o;
    logic        self_ref_o;
    logic [1:0]  wr_mask_o;
    logic [1:0]  rd_mask_o;

    int total = 0;
    int bad   = 0;
    int exp_ref = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
        .cmd_o(cmd_o), .err_o(err_o), .bank_open_o(bank_open_o),
        .open_rows_o(open_rows_o), .mode_o(mode_o),
        .refresh_row_o(refresh_row_o), .self_ref_o(self_ref_o),
        .wr_mask_o(wr_mask_o), .rd_mask_o(rd_mask_o)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive pins at the falling edge, return after the next rising edge.
    task automatic step(input logic c, input logic r, input logic ca, input logic w,
                        input logic k, input logic [1:0] b, input logic [11:0] a,
                        input logic [1:0] m);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k;
        ba = b; addr = a; dqm = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();                           step(1,1,1,1,1,2'd0,12'h0,2'd0); endtask
    task automatic act(input int b, input int row); step(0,0,1,1,1,2'(b),12'(row),2'd0); endtask
    task automatic rd(input int b, input bit ap);   step(0,1,0,1,1,2'(b),ap ? 12'h400 : 12'h0,2'd0); endtask
    task automatic wr(input int b, input bit ap);   step(0,1,0,0,1,2'(b),ap ? 12'h400 : 12'h0,2'd0); endtask
    task automatic pre(input int b);                step(0,0,1,0,1,2'(b),12'h0,2'd0); endtask
    task automatic preall(input int b);             step(0,0,1,0,1,2'(b),12'h400,2'd0); endtask
    task automatic aref();                          step(0,0,0,1,1,2'd0,12'h0,2'd0); endtask
    task automatic lmr(input int code);             step(0,0,0,0,1,2'd0,12'(code),2'd0); endtask

    function automatic int exp_cmd(bit c, bit r, bit ca, bit w, bit k, bit a10);
        if (c) return 0;
        case ({r, ca, w})
            3'b111: return 0;
            3'b011: return 1;
            3'b101: return 2;
            3'b100: return 3;
            3'b110: return 4;
            3'b010: return a10 ? 6 : 5;
            3'b001: return k ? 7 : 8;
            default: return 9;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hist [20];
        rst_n = 1'b0;
        cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; ba = 0; addr = 0; dqm = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 cmd",   48'(cmd_o), 0);
        check("R11 err",   48'(err_o), 0);
        check("R11 banks", 48'(bank_open_o), 0);
        check("R11 mode",  48'(mode_o), 0);
        check("R11 ref",   48'(refresh_row_o), 0);
        check("R11 self",  48'(self_ref_o), 0);
        check("R11 masks", 48'({wr_mask_o, rd_mask_o}), 0);

        // R1/R2: sweep every pin combination with banks idle
        for (int i = 0; i < 16; i++) begin
            bit c, r, ca, w;
            int ec;
            {c, r, ca, w} = 4'(i);
            ec = exp_cmd(c, r, ca, w, 1'b1, 1'b0);
            step(c, r, ca, w, 1'b1, 2'd1, 12'h0, 2'd0);
            if (ec == 7) exp_ref++;
            check(c ? "R1 inhibit cmd" : "R2 decode cmd", 48'(cmd_o), 48'(ec));
            check("R10 idle access err", 48'(err_o), (ec == 2 || ec == 3) ? 48'd1 : 48'd0);
            check("R6 refresh count", 48'(refresh_row_o), 48'(exp_ref));
            check("R1 banks after", 48'(bank_open_o), (ec == 1) ? 48'd2 : 48'd0);
            check("R8 mode after sweep", 48'(mode_o), 0);
            preall(3);
            check("R4 precharge all cmd", 48'(cmd_o), 6);
            check("R4 precharge all", 48'(bank_open_o), 0);
        end

        // R5/R3/R8: burst length sweep, every bank, reads and writes
        for (int code = 0; code < 8; code++) begin
            for (int b = 0; b < 4; b++) begin
                for (int op = 0; op < 2; op++) begin
                    int bl;
                    int row;
                    bl  = code[2] ? 8 : (1 << code[1:0]);
                    row = (code * 211 + b * 37 + op * 5) & 12'hfff;
                    lmr(code);
                    check("R8 mode stored", 48'(mode_o), 48'(code));
                    act(b, row);
                    check("R3 bank opened", 48'(bank_open_o), 48'(1 << b));
                    check("R3 row stored", 48'(open_rows_o[b*12 +: 12]), 48'(row));
                    if (op == 0) rd(b, 1'b1); else wr(b, 1'b1);
                    check("R5 access cmd", 48'(cmd_o), op == 0 ? 48'd2 : 48'd3);
                    for (int j = 1; j <= bl; j++) begin
                        nop();
                        check("R5 auto precharge timing", 48'(bank_open_o[b]), (j < bl) ? 48'd1 : 48'd0);
                    end
                end
            end
        end

        // R5: access without auto precharge keeps the bank open
        act(0, 12'h123);
        rd(0, 1'b0);
        repeat (10) nop();
        check("R5 no auto precharge", 48'(bank_open_o), 1);
        wr(0, 1'b0);
        repeat (10) nop();
        check("R5 no auto precharge write", 48'(bank_open_o), 1);

        // R4: single precharge only closes its bank
        act(1, 12'h0a1); act(2, 12'h0b2); act(3, 12'h0c3);
        check("R3 all open", 48'(bank_open_o), 4'hf);
        pre(2);
        check("R4 single cmd", 48'(cmd_o), 5);
        check("R4 single close", 48'(bank_open_o), 4'hb);
        check("R4 rows kept", 48'(open_rows_o[12 +: 12]), 12'h0a1);

        // R10: error cases leave state untouched
        act(1, 12'hfff);
        check("R10 act open err", 48'(err_o), 2);
        check("R10 act open row", 48'(open_rows_o[12 +: 12]), 12'h0a1);
        lmr(3);
        check("R10 lmr busy err", 48'(err_o), 4);
        check("R10 lmr busy mode", 48'(mode_o), 7);
        aref();
        check("R10 aref busy err", 48'(err_o), 4);
        check("R10 aref busy ref", 48'(refresh_row_o), 48'(exp_ref));
        step(0,0,0,1,0,2'd0,12'h0,2'd0);
        check("R10 sref busy err", 48'(err_o), 4);
        check("R10 sref busy self", 48'(self_ref_o), 0);
        rd(2, 1'b0);
        check("R10 read idle err", 48'(err_o), 1);
        step(1,1,1,1,0,2'd0,12'h0,2'd0);
        check("R10 cke low nop err", 48'(err_o), 8);
        step(0,0,1,0,0,2'd3,12'h400,2'd0);
        check("R10 cke low pre err", 48'(err_o), 8);
        check("R10 cke low pre ignored", 48'(bank_open_o), 4'hb);
        preall(0);
        check("R4 precharge all ba ignored", 48'(bank_open_o), 0);

        // R6: auto refresh steps
        for (int i = 0; i < 5; i++) begin
            aref();
            exp_ref++;
            check("R6 refresh step", 48'(refresh_row_o), 48'(exp_ref));
            check("R6 refresh cmd", 48'(cmd_o), 7);
        end

        // R7: self refresh entry, hold, exit and forced NOP
        lmr(1);
        step(0,0,0,1,0,2'd0,12'h0,2'd0);
        check("R7 sref cmd", 48'(cmd_o), 8);
        check("R7 sref flag", 48'(self_ref_o), 1);
        step(0,0,1,1,0,2'd1,12'h055,2'd0);
        check("R7 ignored act", 48'(bank_open_o), 0);
        check("R7 ignored cmd", 48'(cmd_o), 0);
        check("R7 no cke err", 48'(err_o), 0);
        step(0,0,0,1,0,2'd0,12'h0,2'd0);
        check("R7 ref frozen", 48'(refresh_row_o), 48'(exp_ref));
        check("R7 still self", 48'(self_ref_o), 1);
        step(0,0,1,1,1,2'd1,12'h055,2'd0);
        check("R7 exit flag", 48'(self_ref_o), 0);
        check("R7 exit cmd", 48'(cmd_o), 0);
        check("R7 exit no act", 48'(bank_open_o), 0);
        act(1, 12'h066);
        check("R7 forced nop cmd", 48'(cmd_o), 0);
        check("R7 forced nop bank", 48'(bank_open_o), 0);
        act(1, 12'h077);
        check("R7 resumed act", 48'(bank_open_o), 2);
        check("R7 resumed row", 48'(open_rows_o[12 +: 12]), 12'h077);
        preall(0);

        // R5/R10: countdown end coincides with a new activate (BL=2)
        act(0, 12'h011);
        rd(0, 1'b1);
        nop();
        act(0, 12'h022);
        check("R10 act at close err", 48'(err_o), 2);
        check("R5 closed on same edge", 48'(bank_open_o), 0);
        act(0, 12'h033);
        check("R10 act after close err", 48'(err_o), 0);
        check("R3 act after close row", 48'(open_rows_o[11:0]), 12'h033);
        preall(0);

        // R9: mask latencies
        for (int i = 0; i < 20; i++) begin
            hist[i] = (i * 3 + 1) % 4;
            step(1,1,1,1,1,2'd0,12'h0,2'(hist[i]));
            check("R9 write mask", 48'(wr_mask_o), 48'(hist[i]));
            if (i >= 2) check("R9 read mask", 48'(rd_mask_o), 48'(hist[i-2]));
        end

        // R1: inhibit with strobes low changes nothing
        step(1,0,0,0,1,2'd0,12'h5a5,2'd0);
        check("R1 inhibit cmd", 48'(cmd_o), 0);
        check("R1 inhibit mode", 48'(mode_o), 1);
        check("R1 inhibit ref", 48'(refresh_row_o), 48'(exp_ref));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule